// File: doc/BRIEF.md
# Shadowed Layer Configuration Reload Controller

This block keeps every per-layer configuration word twice: a shadow copy that software writes, and an active copy that the display pipeline reads. Writes never reach the active copy directly. A reload request, issued through a control register, transfers the whole shadow bank into the active bank in one cycle. Software can ask for the transfer to happen straight away, or to wait until the timing generator reports vertical blanking, so that a frame never mixes old and new settings.

Each layer also owns a lookup-table write port. It is not shadowed: a write to it is forwarded to the table at once as a one-cycle strobe carrying the data. The block also holds four interrupt flags: a line event, an underrun, a transfer error and reload-done. Each flag has an enable bit and a write-one-to-clear bit, and a single interrupt output combines them.

Top module: `shadow_reload_ctrl`

## Requirements
- R1: After reset, every active word is 0, both pending bits are 0, all status flags are 0 and `irq` is 0.
- R2: A write to a layer word updates only the shadow copy, and `active_cfg` changes only on a reload copy. With the default parameters, word r (0..3) of layer l (0..1) is at address 8 + 8*l + r. Active word l*4+r sits at bits [(l*4+r)*32 +: 32].
- R3: A write to address 0 with bit 0 set makes `reload_pending[0]` read 1 for exactly one cycle. At the following clock edge the shadow bank is copied into the active bank and the bit clears.
- R4: A write to address 0 with bit 1 set makes `reload_pending[1]` read 1. The bit stays set until a later clock edge at which `vblank` is high. At that edge the copy takes place and the bit clears.
- R5: A control write with bit 0 set always leaves `reload_pending[1]` at 0. This applies whether bit 1 is set in the same write or a blanking request is already waiting, so the immediate request wins.
- R6: A control write with bits 1:0 equal to 0 leaves a waiting request untouched.
- R7: A write to address 12 + 8*l pulses `lut_wr_stb[l]` for one cycle, starting the cycle after the write, with `lut_wr_data` equal to the written data. The write does not affect shadow or active words.
- R8: Every reload copy, whether immediate or at blanking, sets status bit 3 (reload-done).
- R9: Pulses on `line_evt`, `underrun_evt` and `xfer_err_evt` set status bits 0, 1 and 2 respectively.
- R10: A write to address 2 clears each status flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R11: `irq` is the OR over all flags of status AND enable. The enable bits are bits 3:0 written to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| vblank | input | 1 | Vertical blanking indication from the timing generator |
| line_evt | input | 1 | Line-position event pulse |
| underrun_evt | input | 1 | Pixel underrun event pulse |
| xfer_err_evt | input | 1 | Bus transfer error event pulse |
| active_cfg | output | 256 | All active configuration words, flattened |
| lut_wr_stb | output | 2 | Per-layer lookup-table write strobe |
| lut_wr_data | output | 32 | Lookup-table write data |
| reload_pending | output | 2 | Readback of the waiting reload requests (bit 0 immediate, bit 1 blanking) |
| irq_status | output | 4 | Interrupt flags: line, underrun, transfer error, reload-done |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are the collisions around a waiting blanking request. These include a new control write landing while one is pending, `vblank` already high on the very edge that registers the request, and a flag clear coinciding with the copy that sets the same flag. The stimulus holds `vblank` low while it issues neutral and immediate control writes over a pending blanking request. It then raises `vblank` together with the request write, and issues a clear of reload-done on the exact cycle of a blanking copy. A behavioural model compares every output on every cycle throughout.

// File: rtl/shadow_reload_pkg.sv
package shadow_reload_pkg;
  localparam int unsigned CTRL_ADDR  = 0;
  localparam int unsigned IEN_ADDR   = 1;
  localparam int unsigned ICLR_ADDR  = 2;
  localparam int unsigned LAYER_BASE = 8;

  localparam int unsigned FLAG_LINE = 0;
  localparam int unsigned FLAG_UDR  = 1;
  localparam int unsigned FLAG_TERR = 2;
  localparam int unsigned FLAG_RLD  = 3;
  localparam int unsigned NUM_FLAGS = 4;

  // address slots per layer: the words plus one lookup-table port, rounded up
  function automatic int unsigned slot_bits(input int unsigned regs);
    return $clog2(regs + 1);
  endfunction

  function automatic int unsigned word_addr(input int unsigned layer,
                                            input int unsigned idx,
                                            input int unsigned regs);
    return LAYER_BASE + layer * (1 << slot_bits(regs)) + idx;
  endfunction

  function automatic int unsigned lut_addr(input int unsigned layer,
                                           input int unsigned regs);
    return word_addr(layer, regs, regs);
  endfunction

  // a set in the same cycle as a clear wins
  function automatic logic [NUM_FLAGS-1:0] flag_next(input logic [NUM_FLAGS-1:0] cur,
                                                     input logic [NUM_FLAGS-1:0] clr,
                                                     input logic [NUM_FLAGS-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/srl_shadow_bank.sv
module srl_shadow_bank
  import shadow_reload_pkg::*;
#(
  parameter int unsigned NUM_LAYERS = 2,
  parameter int unsigned REGS       = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             copy,
  output logic [NUM_LAYERS*REGS*DATA_W-1:0] active_cfg,
  output logic [NUM_LAYERS-1:0]            lut_stb,
  output logic [DATA_W-1:0]                lut_data
);
  localparam int unsigned WORDS = NUM_LAYERS * REGS;

  logic [NUM_LAYERS-1:0] lut_hit;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    assign lut_hit[l] = wr_en && (wr_addr == ADDR_W'(lut_addr(l, REGS)));
    for (genvar r = 0; r < REGS; r++) begin : g_word
      localparam int unsigned W = l * REGS + r;
      logic              hit;
      logic [DATA_W-1:0] shadow_q;
      logic [DATA_W-1:0] active_q;
      assign hit = wr_en && (wr_addr == ADDR_W'(word_addr(l, r, REGS)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_q <= '0;
          active_q <= '0;
        end else begin
          if (copy) active_q <= shadow_q;
          if (hit)  shadow_q <= wr_data;
        end
      end
      assign active_cfg[W*DATA_W +: DATA_W] = active_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_stb  <= '0;
      lut_data <= '0;
    end else begin
      lut_stb <= lut_hit;
      if (|lut_hit) lut_data <= wr_data;
    end
  end

  if (WORDS == 0) begin : g_bad
    initial $display("srl_shadow_bank: empty bank");
  end
endmodule

// File: rtl/srl_reload_seq.sv
module srl_reload_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  input  logic       vblank,
  output logic [1:0] pending,
  output logic       copy
);
  logic imm_q, blank_q;
  logic blank_fire;

  assign blank_fire = blank_q && vblank;
  assign copy       = imm_q || blank_fire;
  assign pending    = {blank_q, imm_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q   <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      imm_q <= ctrl_wr && ctrl_bits[0];
      if (ctrl_wr && ctrl_bits[0])      blank_q <= 1'b0;
      else if (ctrl_wr && ctrl_bits[1]) blank_q <= 1'b1;
      else if (blank_fire)              blank_q <= 1'b0;
    end
  end
endmodule

// File: rtl/srl_irq_unit.sv
module srl_irq_unit
  import shadow_reload_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ien_wr,
  input  logic                 iclr_wr,
  input  logic [NUM_FLAGS-1:0] wr_bits,
  input  logic [NUM_FLAGS-1:0] set_bits,
  output logic [NUM_FLAGS-1:0] status,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] enable_q;
  logic [NUM_FLAGS-1:0] clr_bits;

  assign clr_bits = iclr_wr ? wr_bits : '0;
  assign irq      = |(status & enable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      enable_q <= '0;
    end else begin
      status <= flag_next(status, clr_bits, set_bits);
      if (ien_wr) enable_q <= wr_bits;
    end
  end
endmodule

// File: rtl/shadow_reload_ctrl.sv
module shadow_reload_ctrl
  import shadow_reload_pkg::*;
#(
  parameter int unsigned NUM_LAYERS = 2,
  parameter int unsigned REGS       = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              vblank,
  input  logic                              line_evt,
  input  logic                              underrun_evt,
  input  logic                              xfer_err_evt,
  output logic [NUM_LAYERS*REGS*DATA_W-1:0] active_cfg,
  output logic [NUM_LAYERS-1:0]             lut_wr_stb,
  output logic [DATA_W-1:0]                 lut_wr_data,
  output logic [1:0]                        reload_pending,
  output logic [NUM_FLAGS-1:0]              irq_status,
  output logic                              irq
);
  logic ctrl_wr, ien_wr, iclr_wr;
  logic copy_fire;
  logic [NUM_FLAGS-1:0] flag_set;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign ien_wr  = wr_en && (wr_addr == ADDR_W'(IEN_ADDR));
  assign iclr_wr = wr_en && (wr_addr == ADDR_W'(ICLR_ADDR));

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_LINE] = line_evt;
    flag_set[FLAG_UDR]  = underrun_evt;
    flag_set[FLAG_TERR] = xfer_err_evt;
    flag_set[FLAG_RLD]  = copy_fire;
  end

  srl_reload_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bits (wr_data[1:0]),
    .vblank    (vblank),
    .pending   (reload_pending),
    .copy      (copy_fire)
  );

  srl_shadow_bank #(
    .NUM_LAYERS (NUM_LAYERS),
    .REGS       (REGS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .copy       (copy_fire),
    .active_cfg (active_cfg),
    .lut_stb    (lut_wr_stb),
    .lut_data   (lut_wr_data)
  );

  srl_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ien_wr   (ien_wr),
    .iclr_wr  (iclr_wr),
    .wr_bits  (wr_data[NUM_FLAGS-1:0]),
    .set_bits (flag_set),
    .status   (irq_status),
    .irq      (irq)
  );
endmodule

// File: rtl/shadow_reload_ctrl_chk.sv
module shadow_reload_ctrl_chk #(
  parameter int unsigned CFG_W  = 256,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              vblank,
  input logic [CFG_W-1:0]  active_cfg,
  input logic [1:0]        reload_pending,
  input logic [3:0]        irq_status,
  input logic              irq,
  input logic              copy_fire
);
  logic ctrl_w, iclr_w;
  assign ctrl_w = wr_en && (wr_addr == ADDR_W'(0));
  assign iclr_w = wr_en && (wr_addr == ADDR_W'(2));

  // R2
  active_only_on_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_fire |=> $stable(active_cfg));

  // R3
  immediate_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pending[0] |=> irq_status[3]);

  // R4
  blank_request_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pending[1] && !vblank && !(ctrl_w && wr_data[0])) |=> reload_pending[1]);

  // R5
  immediate_cancels_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && wr_data[0]) |=> (reload_pending == 2'b01));

  // R10
  clear_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iclr_w && wr_data[3] && !copy_fire) |=> !irq_status[3]);

  // R11
  quiet_without_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status == 4'b0) |-> !irq);
endmodule

bind shadow_reload_ctrl shadow_reload_ctrl_chk #(
  .CFG_W  (NUM_LAYERS*REGS*DATA_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .vblank         (vblank),
  .active_cfg     (active_cfg),
  .reload_pending (reload_pending),
  .irq_status     (irq_status),
  .irq            (irq),
  .copy_fire      (copy_fire)
);

// File: tb/shadow_reload_ctrl_test.sv
module shadow_reload_ctrl_test;
  localparam int NL = 2;
  localparam int NR = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [5:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic vblank = 0;
  logic line_evt = 0, underrun_evt = 0, xfer_err_evt = 0;
  logic [NL*NR*32-1:0] active_cfg;
  logic [NL-1:0] lut_wr_stb;
  logic [31:0] lut_wr_data;
  logic [1:0] reload_pending;
  logic [3:0] irq_status;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shadow_reload_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .line_evt(line_evt), .underrun_evt(underrun_evt),
    .xfer_err_evt(xfer_err_evt), .active_cfg(active_cfg), .lut_wr_stb(lut_wr_stb),
    .lut_wr_data(lut_wr_data), .reload_pending(reload_pending),
    .irq_status(irq_status), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_sh [NL*NR];
  logic [31:0] m_ac [NL*NR];
  bit m_imm, m_blank;
  logic [3:0] m_st, m_en;
  logic [NL-1:0] m_lstb;
  logic [31:0] m_ldat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL*NR; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
      m_imm = 0; m_blank = 0; m_st = 0; m_en = 0; m_lstb = 0; m_ldat = 0;
    end else begin
      bit cp;
      logic [3:0] clr;
      cp = m_imm || (m_blank && vblank);
      if (cp) for (int i = 0; i < NL*NR; i++) m_ac[i] = m_sh[i];
      m_lstb = 0;
      for (int l = 0; l < NL; l++) begin
        if (wr_en && wr_addr == 12 + 8*l) begin m_lstb[l] = 1; m_ldat = wr_data; end
        for (int r = 0; r < NR; r++)
          if (wr_en && wr_addr == 8 + 8*l + r) m_sh[l*NR+r] = wr_data;
      end
      clr = (wr_en && wr_addr == 2) ? wr_data[3:0] : 4'b0;
      m_st = (m_st & ~clr) | {cp, xfer_err_evt, underrun_evt, line_evt};
      if (wr_en && wr_addr == 1) m_en = wr_data[3:0];
      if (m_blank && vblank) m_blank = 0;
      m_imm = 0;
      if (wr_en && wr_addr == 0) begin
        if (wr_data[0]) begin m_imm = 1; m_blank = 0; end
        else if (wr_data[1]) m_blank = 1;
      end
    end
  end

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NL*NR*32-1:0] exp_ac;
      for (int i = 0; i < NL*NR; i++) exp_ac[i*32 +: 32] = m_ac[i];
      check("R2 active_cfg", active_cfg, exp_ac);
      check("R3 pending immediate", reload_pending[0], m_imm);
      check("R4 pending blank", reload_pending[1], m_blank);
      check("R8 reload flag", irq_status[3], m_st[3]);
      check("R9 event flags", irq_status[2:0], m_st[2:0]);
      check("R11 irq", irq, |(m_st & m_en));
      check("R7 lut strobe", lut_wr_stb, m_lstb);
      if (|m_lstb) check("R7 lut data", lut_wr_data, m_ldat);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    // R1 reset state
    check("R1 active", active_cfg, '0);
    check("R1 pending", reload_pending, 2'b00);
    check("R1 status", irq_status, 4'h0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1;
    idle(1);
    // R2 shadow writes only
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NR; r++) wr(8 + 8*l + r, 32'hA000_0000 + 32'(l*16 + r));
    idle(2);
    check("R2 no change before reload", active_cfg, '0);
    // R3 immediate
    wr(0, 32'h1);
    idle(2);
    check("R3 word0 copied", active_cfg[31:0], 32'hA000_0000);
    // R11 enable and R10 clear
    wr(1, 32'h8);
    idle(1);
    check("R11 irq asserted", irq, 1'b1);
    wr(2, 32'h0);
    check("R10 zero clear keeps flag", irq_status[3], 1'b1);
    wr(2, 32'h8);
    check("R10 clear drops flag", irq_status[3], 1'b0);
    // R4 blanking reload
    wr(9, 32'h1234_5678);
    wr(0, 32'h2);
    idle(4);
    check("R4 still waiting", reload_pending, 2'b10);
    // R6 neutral control write
    wr(0, 32'h0);
    check("R6 request kept", reload_pending, 2'b10);
    vblank = 1; idle(1); vblank = 0;
    idle(1);
    check("R4 copied at blank", active_cfg[63:32], 32'h1234_5678);
    // R5 both bits together, and immediate over a waiting request
    wr(0, 32'h2);
    wr(0, 32'h3);
    check("R5 both bits", reload_pending, 2'b01);
    idle(2);
    wr(0, 32'h2);
    wr(0, 32'h1);
    check("R5 cancel waiting", reload_pending, 2'b01);
    vblank = 1; idle(2); vblank = 0;
    check("R5 nothing left", reload_pending, 2'b00);
    // request issued while vblank already high
    vblank = 1;
    wr(10, 32'hCAFE_0001);
    wr(0, 32'h2);
    vblank = 0;
    idle(1);
    vblank = 1; idle(1); vblank = 0;
    // R10 clear coinciding with a blank copy: set wins
    wr(0, 32'h2);
    vblank = 1;
    wr(2, 32'h8);
    vblank = 0;
    check("R10 set wins", irq_status[3], 1'b1);
    // R7 lookup-table ports
    wr(12, 32'h0011_2233);
    wr(20, 32'h4455_6677);
    idle(2);
    // R9 events and R11 enables
    wr(1, 32'h5);
    line_evt = 1; @(negedge clk); line_evt = 0;
    underrun_evt = 1; @(negedge clk); underrun_evt = 0;
    xfer_err_evt = 1; @(negedge clk); xfer_err_evt = 0;
    check("R9 all event flags", irq_status[2:0], 3'b111);
    wr(2, 32'hF);
    check("R10 clear all", irq_status, 4'h0);
    check("R11 irq low", irq, 1'b0);
    underrun_evt = 1; @(negedge clk); underrun_evt = 0;
    check("R11 masked flag", irq, 1'b0);
    idle(3);
    finish_run();
  end
endmodule